// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is the slave side of a small serial EEPROM on an I2C bus. A fast system clock samples the bus lines through two-flop synchronizers. Start and Stop are found from SDA edges while SCL is high. Bytes are shifted in on SCL rising edges and acknowledged by pulling SDA low through an open-drain output enable. The storage is a 256-byte array built from registers. After reset every byte reads 0xFF.

A write command carries the device select byte, then a word address, then any number of data bytes. The data bytes go into a 16-byte page buffer. The buffer index wraps inside the addressed page. A Stop commits the buffered bytes and starts a timed internal write cycle. During that cycle the block does not watch the bus, so a master can poll for the end of the cycle by sending the device select byte until it is acknowledged.

A read command returns bytes MSB first, starting at the current address pointer. The pointer increments after every byte and wraps at the end of the array. A write that carries an address but no data only loads the pointer. This gives a random read when a repeated Start and a read command follow. A write-control input blocks all data writes.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After a Start, the first byte is acknowledged only when its bits 7:4 equal 1010 and its bits 3:1 equal `strapAddr`; bit 0 selects read (1) or write (0). On a mismatch the block gives no acknowledge and ignores every following byte until the next Start.
- R2: A Stop returns the block to standby. A read byte answered with NoAck and then a Stop ends the read. A write command stopped before any data byte starts no write cycle, and the next device select byte is acknowledged at once.
- R3: For each byte it accepts, the block drives `sdaOe` high during the 9th SCL pulse. It releases SDA at the end of that pulse and during the master's acknowledge slot after a read byte. `sdaOe` changes only while the synchronized SCL is low.
- R4: After reset all 256 array bytes read 0xFF. A write of one data byte followed by Stop stores that byte at the given address.
- R5: Data bytes of one write command are held in a 16-byte page buffer. Address bits 3:0 step and wrap inside the page while bits 7:4 stay fixed. A later byte to the same buffer slot replaces the earlier one. The buffered bytes reach the array only on Stop.
- R6: A Stop that ends a write command with at least one stored data byte starts an internal write cycle of `WRITE_CLKS` system clocks. During the cycle SDA is never driven and Starts are ignored, so the device select byte is not acknowledged. After the cycle the device select byte is acknowledged again.
- R7: A write command with an address and no data bytes loads the address pointer. A following read command, after a repeated Start or after a Stop and a new Start, returns the byte at that address.
- R8: A read returns data MSB first. The pointer increments after each byte and wraps from 0xFF to 0x00, so a sequential read returns consecutive array bytes for as long as the master acknowledges.
- R9: While `writeCtl` is high, the device select and address bytes of a write are acknowledged but data bytes are not. The array is unchanged, and no write cycle starts.
- R10: During and right after reset, `sdaOe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| strapAddr | input | 3 | Device address bits matched against device select bits 3:1 |
| writeCtl | input | 1 | High blocks all data writes to the array |
| sdaOe | output | 1 | Open-drain enable; high pulls SDA low |

## Verification
The checks assume a well-formed bus. SDA changes only while SCL is low, except when it forms a Start or a Stop. The master never makes a Start or a Stop while the block holds SDA low. `writeCtl` stays constant for the whole of a write command. The stimulus meets these rules by building every bus phase from fixed SCL quarter and half periods of several system clocks, changed only on falling clock edges. It also changes `writeCtl` only between commands. A sweep writes every page of the array and then reads the whole array back in one sequential read, so that every cell and the pointer wrap are compared with a model in the bench.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  // Strobes from the control FSM to the datapath, at most one data action per cycle
  typedef struct packed {
    logic shiftIn;    // sample SDA into the receive shifter
    logic loadAddr;   // received byte becomes the address pointer
    logic storeData;  // received byte goes to the page buffer
    logic loadRead;   // fetch array byte at pointer into transmit shifter
    logic shiftOut;   // advance the transmit shifter by one bit
    logic commit;     // copy buffered page bytes into the array
    logic clearPage;  // drop buffered page bytes
  } dpStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVSEL,
    ST_DEVACK,
    ST_ADDR,
    ST_ADDRACK,
    ST_WDATA,
    ST_WDACK,
    ST_RDATA,
    ST_RDACK,
    ST_WRCYCLE
  } ctrlState_t;

endpackage

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter int WRITE_CLKS  = 250000,
  parameter int SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapAddr,
  input  logic       writeCtl,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  input  logic       hasPending,
  output dpStrobe_t  stb,
  output logic       sdaOe,
  output logic       sclLevel,
  output logic       sdaLevel,
  output logic       busy
);

  localparam int TIMER_W = $clog2(WRITE_CLKS + 1);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclDly, sdaDly;
  logic sclRise, sclFall, startSeen, stopSeen;

  ctrlState_t st, stNext;
  logic [3:0] bitCnt, bitNext;
  logic ackReg, ackNext;
  logic mAck, mAckNext;
  logic [TIMER_W-1:0] timer, timerNext;
  logic devMatch;

  // Two-stage synchronizers, then one delay stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclDly  <= 1'b1;
      sdaDly  <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclDly  <= sclPipe[SYNC_STAGES-1];
      sdaDly  <= sdaPipe[SYNC_STAGES-1];
    end
  end

  assign sclLevel  = sclPipe[SYNC_STAGES-1];
  assign sdaLevel  = sdaPipe[SYNC_STAGES-1];
  assign sclRise   = sclLevel & ~sclDly;
  assign sclFall   = ~sclLevel & sclDly;
  assign startSeen = sclLevel & sclDly & sdaDly & ~sdaLevel;
  assign stopSeen  = sclLevel & sclDly & ~sdaDly & sdaLevel;

  assign devMatch = (rxByte[7:4] == DEV_CODE) && (rxByte[3:1] == strapAddr);

  always_comb begin
    stNext    = st;
    bitNext   = bitCnt;
    ackNext   = ackReg;
    mAckNext  = mAck;
    timerNext = timer;
    stb       = '0;
    if (st == ST_WRCYCLE) begin
      if (timer == '0) stNext = ST_IDLE;
      else             timerNext = timer - 1'b1;
    end else if (startSeen) begin
      stNext        = ST_DEVSEL;
      bitNext       = '0;
      ackNext       = 1'b0;
      stb.clearPage = 1'b1;
    end else if (stopSeen) begin
      ackNext = 1'b0;
      bitNext = '0;
      if ((st == ST_WDATA || st == ST_WDACK) && hasPending) begin
        stNext     = ST_WRCYCLE;
        stb.commit = 1'b1;
        timerNext  = TIMER_W'(WRITE_CLKS - 1);
      end else begin
        stNext = ST_IDLE;
      end
    end else begin
      unique case (st)
        ST_DEVSEL, ST_ADDR, ST_WDATA: begin
          if (sclRise && bitCnt != 4'd8) begin
            stb.shiftIn = 1'b1;
            bitNext     = bitCnt + 1'b1;
          end
          if (sclFall && bitCnt == 4'd8) begin
            bitNext = '0;
            if (st == ST_DEVSEL) begin
              ackNext = devMatch;
              stNext  = ST_DEVACK;
            end else if (st == ST_ADDR) begin
              ackNext      = 1'b1;
              stb.loadAddr = 1'b1;
              stNext       = ST_ADDRACK;
            end else begin
              ackNext       = ~writeCtl;
              stb.storeData = ~writeCtl;
              stNext        = ST_WDACK;
            end
          end
        end
        ST_DEVACK: begin
          if (sclFall) begin
            ackNext = 1'b0;
            if (!ackReg) begin
              stNext = ST_IDLE;
            end else if (rxByte[0]) begin
              stb.loadRead = 1'b1;
              stNext       = ST_RDATA;
            end else begin
              stNext = ST_ADDR;
            end
          end
        end
        ST_ADDRACK, ST_WDACK: begin
          if (sclFall) begin
            ackNext = 1'b0;
            stNext  = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (sclRise && bitCnt != 4'd8) bitNext = bitCnt + 1'b1;
          if (sclFall) begin
            if (bitCnt == 4'd8) begin
              bitNext = '0;
              stNext  = ST_RDACK;
            end else if (bitCnt != '0) begin
              stb.shiftOut = 1'b1;
            end
          end
        end
        ST_RDACK: begin
          if (sclRise) mAckNext = ~sdaLevel;
          if (sclFall) begin
            if (mAck) begin
              stb.loadRead = 1'b1;
              stNext       = ST_RDATA;
            end else begin
              stNext = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      bitCnt <= '0;
      ackReg <= 1'b0;
      mAck   <= 1'b0;
      timer  <= '0;
    end else begin
      st     <= stNext;
      bitCnt <= bitNext;
      ackReg <= ackNext;
      mAck   <= mAckNext;
      timer  <= timerNext;
    end
  end

  always_comb begin
    unique case (st)
      ST_DEVACK, ST_ADDRACK, ST_WDACK: sdaOe = ackReg;
      ST_RDATA:                        sdaOe = ~txBit;
      default:                         sdaOe = 1'b0;
    endcase
  end

  assign busy = (st == ST_WRCYCLE);

endmodule

// File: rtl/eeprom_datapath.sv
module eeprom_datapath
  import eeprom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4,
  parameter logic [7:0] ERASED = 8'hFF
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  stb,
  input  logic       sdaBit,
  output logic [7:0] rxByte,
  output logic       txBit,
  output logic       hasPending
);

  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int ROW_W      = ADDR_W - PAGE_W;

  logic [7:0] mem [DEPTH];
  logic [7:0] pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageVld;
  logic [ADDR_W-1:0] ptr;
  logic [7:0] rxShift, txShift;
  logic [PAGE_W-1:0] slot;
  logic [ROW_W-1:0] row;

  assign slot = ptr[PAGE_W-1:0];
  assign row  = ptr[ADDR_W-1:PAGE_W];

  // Receive and transmit shifters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
    end else begin
      if (stb.shiftIn)  rxShift <= {rxShift[6:0], sdaBit};
      if (stb.loadRead) txShift <= mem[ptr];
      else if (stb.shiftOut) txShift <= {txShift[6:0], 1'b1};
    end
  end

  // Address pointer: full increment on reads, in-page increment on writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (stb.loadAddr) begin
      ptr <= rxShift[ADDR_W-1:0];
    end else if (stb.loadRead) begin
      ptr <= ptr + 1'b1;
    end else if (stb.storeData) begin
      ptr <= {row, slot + 1'b1};
    end
  end

  // Page buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageVld <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= '0;
    end else if (stb.clearPage || stb.commit) begin
      pageVld <= '0;
    end else if (stb.storeData) begin
      pageBuf[slot] <= rxShift;
      pageVld[slot] <= 1'b1;
    end
  end

  // Storage array, written only by a page commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (stb.commit) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (pageVld[PAGE_W'(i)] && (row == ROW_W'(i >> PAGE_W)))
          mem[i] <= pageBuf[PAGE_W'(i)];
      end
    end
  end

  assign rxByte     = rxShift;
  assign txBit      = txShift[7];
  assign hasPending = |pageVld;

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int WRITE_CLKS  = 250000,
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapAddr,
  input  logic       writeCtl,
  output logic       sdaOe
);

  dpStrobe_t  stb;
  logic [7:0] rxByte;
  logic       txBit, hasPending, sclLevel, sdaLevel, busy;

  eeprom_ctrl #(
    .WRITE_CLKS (WRITE_CLKS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .strapAddr (strapAddr),
    .writeCtl  (writeCtl),
    .rxByte    (rxByte),
    .txBit     (txBit),
    .hasPending(hasPending),
    .stb       (stb),
    .sdaOe     (sdaOe),
    .sclLevel  (sclLevel),
    .sdaLevel  (sdaLevel),
    .busy      (busy)
  );

  eeprom_datapath #(
    .ADDR_W(ADDR_W),
    .PAGE_W(PAGE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .sdaBit    (sdaLevel),
    .rxByte    (rxByte),
    .txBit     (txBit),
    .hasPending(hasPending)
  );

endmodule

// File: rtl/eeprom_slave_checker.sv
module eeprom_slave_checker
  import eeprom_pkg::*;
#(
  parameter int WRITE_CLKS = 250000
) (
  input logic      clk,
  input logic      rstN,
  input logic      sdaOe,
  input logic      writeCtl,
  input logic      sclLevel,
  input logic      busy,
  input dpStrobe_t stb
);

  int busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= 0;
  end

  AST_OE_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclLevel && $past(sclLevel)) |-> $stable(sdaOe)); // R3

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadAddr, stb.storeData, stb.loadRead, stb.commit, stb.clearPage})); // R4

  AST_COMMIT_STARTS_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> busy); // R5

  AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !$past(busy)) |-> $past(stb.commit)); // R5

  AST_WRCYCLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe); // R6

  AST_WRCYCLE_NO_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(stb.loadAddr || stb.storeData || stb.loadRead || stb.commit)); // R6

  AST_WRCYCLE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= WRITE_CLKS); // R6

  AST_PROTECT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    writeCtl |-> !stb.commit); // R9

  AST_RESET_RELEASED: assert property (@(posedge clk)
    !rstN |-> !sdaOe); // R10

endmodule

bind serial_eeprom_slave eeprom_slave_checker #(.WRITE_CLKS(WRITE_CLKS)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .sdaOe   (sdaOe),
  .writeCtl(writeCtl),
  .sclLevel(sclLevel),
  .busy    (busy),
  .stb     (stb)
);

// File: tb/tb_serial_eeprom_slave.sv
module tb_serial_eeprom_slave;

  localparam int CLK_PERIOD = 10;
  localparam int WCLK = 300;
  localparam int Q = 5;
  localparam int H = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic mSdaLow = 1'b0;
  logic writeCtl = 1'b0;
  logic sdaOe;
  wire  sdaLine = !(mSdaLow || sdaOe);

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [7:0] model [256];
  logic [7:0] pat [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_eeprom_slave #(.WRITE_CLKS(WCLK)) dut (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclDrv),
    .sdaIn    (sdaLine),
    .strapAddr(STRAP),
    .writeCtl (writeCtl),
    .sdaOe    (sdaOe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    mSdaLow = 1'b0; tick(Q);
    sclDrv = 1'b1;  tick(H);
    mSdaLow = 1'b1; tick(H);
    sclDrv = 1'b0;  tick(Q);
  endtask

  task automatic busStop();
    mSdaLow = 1'b1; tick(Q);
    sclDrv = 1'b1;  tick(H);
    mSdaLow = 1'b0; tick(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      mSdaLow = !b[i]; tick(Q);
      sclDrv = 1'b1;   tick(H);
      sclDrv = 1'b0;   tick(Q);
    end
    mSdaLow = 1'b0; tick(Q);
    sclDrv = 1'b1;  tick(H/2);
    acked = sdaOe;  tick(H/2);
    sclDrv = 1'b0;  tick(Q);
  endtask

  task automatic readByte(input bit mAck, output logic [7:0] b);
    mSdaLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      sclDrv = 1'b1; tick(H/2);
      b[i] = sdaLine; tick(H/2);
      sclDrv = 1'b0; tick(Q);
    end
    mSdaLow = mAck; tick(Q);
    sclDrv = 1'b1;  tick(H/2);
    checkEq("R3 release in master ack slot", int'(sdaOe), 0);
    tick(H/2);
    sclDrv = 1'b0;  tick(Q);
    mSdaLow = 1'b0;
  endtask

  // Write command with n data bytes from pat; model follows the in-page wrap
  task automatic writeSeq(input logic [7:0] addr, input int n);
    bit a;
    busStart();
    sendByte(DEV_W, a);  checkEq("R1 write select ack", int'(a), 1);
    sendByte(addr, a);   checkEq("R9 address ack", int'(a), 1);
    for (int k = 0; k < n; k++) begin
      sendByte(pat[k], a);
      checkEq(writeCtl ? "R9 data nack" : "R5 data ack", int'(a), int'(!writeCtl));
      if (!writeCtl) model[{addr[7:4], 4'(addr[3:0] + 4'(k))}] = pat[k];
    end
    busStop();
  endtask

  // Random read of n bytes through a repeated Start
  task automatic readSeq(input logic [7:0] addr, input int n, input string req);
    bit a;
    logic [7:0] d;
    busStart();
    sendByte(DEV_W, a); checkEq("R7 select ack", int'(a), 1);
    sendByte(addr, a);  checkEq("R7 address ack", int'(a), 1);
    busStart();
    sendByte(DEV_R, a); checkEq("R7 read select ack", int'(a), 1);
    for (int k = 0; k < n; k++) begin
      readByte(k < n - 1, d);
      checkEq(req, int'(d), int'(model[8'(int'(addr) + k)]));
    end
    busStop();
  endtask

  initial begin
    bit a;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    tick(5);
    checkEq("R10 sdaOe in reset", int'(sdaOe), 0);
    rstN = 1'b1;
    tick(5);
    checkEq("R10 sdaOe after reset", int'(sdaOe), 0);

    // R4: erased contents
    readSeq(8'h00, 1, "R4 erased byte");
    readSeq(8'hA5, 2, "R4 erased bytes");

    // R1: strap mismatch, then bytes without a Start are ignored
    busStart();
    sendByte({4'b1010, STRAP ^ 3'b001, 1'b0}, a);
    checkEq("R1 strap mismatch nack", int'(a), 0);
    sendByte(DEV_W, a);
    checkEq("R1 ignored until Start", int'(a), 0);
    busStop();
    busStart();
    sendByte({4'b1011, STRAP, 1'b0}, a);
    checkEq("R1 code mismatch nack", int'(a), 0);
    busStop();

    // R4 byte write, R6 polling during the write cycle
    pat[0] = 8'h42;
    writeSeq(8'h10, 1);
    busStart();
    sendByte(DEV_W, a);
    checkEq("R6 busy select nack", int'(a), 0);
    busStop();
    tick(WCLK);
    busStart();
    sendByte(DEV_W, a);
    checkEq("R6 select ack after cycle", int'(a), 1);
    busStop();
    readSeq(8'h10, 1, "R4 byte write");

    // R7: address-only write, then current-address reads
    busStart();
    sendByte(DEV_W, a); sendByte(8'h10, a);
    busStop();
    busStart();
    sendByte(DEV_W, a);
    checkEq("R2 no write cycle after address-only", int'(a), 1);
    busStop();
    busStart();
    sendByte(DEV_R, a); checkEq("R7 current read ack", int'(a), 1);
    readByte(1'b0, d);  checkEq("R7 current-address read", int'(d), int'(model[8'h10]));
    busStop();
    busStart();
    sendByte(DEV_R, a);
    readByte(1'b0, d);  checkEq("R2 read after NoAck+Stop", int'(d), int'(model[8'h11]));
    busStop();

    // R5: page write of 20 bytes wrapping in page 0x30
    for (int k = 0; k < 20; k++) pat[k] = 8'(8'h80 + k);
    writeSeq(8'h3C, 20);
    tick(WCLK + 20);
    readSeq(8'h30, 16, "R5 page wrap");

    // R9: write-control high
    writeCtl = 1'b1;
    pat[0] = 8'h77;
    writeSeq(8'h30, 1);
    busStart();
    sendByte(DEV_W, a);
    checkEq("R9 no write cycle", int'(a), 1);
    busStop();
    writeCtl = 1'b0;
    readSeq(8'h30, 1, "R9 array unchanged");

    // R8: sequential read wraps past the array end
    pat[0] = 8'hC3; pat[1] = 8'h3C;
    writeSeq(8'hFF, 2);
    tick(WCLK + 20);
    readSeq(8'hFE, 4, "R8 wrap 0xFF to 0x00");

    // R5/R8 sweep: write every page, read the whole array plus one wrapped byte
    for (int p = 0; p < 16; p++) begin
      for (int c = 0; c < 16; c++) pat[c] = 8'(p * 37 + c * 11 + 5);
      writeSeq(8'(p * 16), 16);
      tick(WCLK + 20);
    end
    readSeq(8'h00, 257, "R8 full sequential read");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 195000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule